// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Register-Driven Insert

This block translates virtual addresses to physical addresses through a 64-entry, fully associative table. Every entry stores a virtual page number, a 13-bit context, a partition identifier, a real-mode flag, a page-size code, a valid bit, a used bit and a physical page number. A lookup is compared against all entries at once. It returns hit, miss or misalignment one cycle later, together with the translated physical address on a hit.

Entries are loaded through a register-style write port in two steps. The first write loads a tag register with the virtual page and the context. A second write carries the page-table word and commits the entry. That commit either names a slot through the write address or leaves the slot to a used-bit replacement scan. A separate write sets the current partition, which is stamped into inserted entries and compared on every lookup. On a hit, the matching entry's used bit is set. The scan takes the lowest-numbered slot that is invalid or not yet used, and falls back to the highest slot when every entry is valid and used.

Top module: `tlb_assoc`

## Requirements
- R1: A write of kind 0 loads the tag register with the data word. Bits 63:13 become the virtual page of the next insert and bits 12:0 its context. A lookup matches only when its context equals the entry's context.
- R2: A write of kind 1 sets the partition register from data bits 7:0. Inserts record it, and a lookup matches an entry only while the partition register equals the entry's partition.
- R3: A write of kind 3 inserts at the slot given by write-address bits 8:3 and replaces whatever that slot held. A freshly inserted entry has its used bit clear.
- R4: A write of kind 2 inserts at the lowest-numbered slot that is invalid or has its used bit clear.
- R5: When every slot is valid and used, a kind 2 insert overwrites the last slot (index 63).
- R6: Write-address bit 9 sets the entry's real-mode flag. A lookup matches only when its real input equals that flag.
- R7: Write-address bit 10 selects the data word encoding. At 0: valid bit 63, size code bits {48,62,61}, physical page bits 39:13. At 1: valid bit 63, size code bits 2:0, physical page bits 39:13.
- R8: A lookup hit sets the used bit of the matching entry, which affects later replacement choices.
- R9: Size code c gives a page of 2^(13+3c) bytes (8 KiB up to 256 MiB). The virtual page is compared only above that page offset. The physical address is the entry's physical page with its offset bits cleared, ORed with the lookup address's offset bits.
- R10: An insert with size code 6 or 7 stores an invalid entry that never hits.
- R11: A lookup whose address has any bit set below 2^size (size input = log2 bytes, 0..3) reports misaligned only, with no hit, no miss and a physical address of 0.
- R12: A lookup that matches no entry reports miss with a physical address of 0. Exactly one of hit, miss and misaligned is raised per completed lookup. If several entries match, the lowest index wins.
- R13: Results appear on the cycle after the request, with a one-cycle done pulse. Out of reset, all lookup outputs are 0.
- R14: An insert whose valid bit (data bit 63) is 0 stores an invalid entry that never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | 0 tag, 1 partition, 2 insert by scan, 3 insert at index |
| wr_addr_i | input | 8 | Write address bits 10:3 (index 8:3, real 9, encoding 10) |
| wr_data_i | input | 64 | Write data word |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 64 | Lookup virtual address |
| lk_ctx_i | input | 13 | Lookup context |
| lk_real_i | input | 1 | Lookup is a real-mode access |
| lk_size_i | input | 2 | Access size as log2 bytes |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No matching entry |
| lk_misalign_o | output | 1 | Address not aligned to access size |
| lk_pa_o | output | 40 | Physical address on a hit, else 0 |

## Verification
Every lookup result is due exactly one clock after the cycle in which the request is presented. A write changes the table at the same edge, so a lookup issued on the following cycle already sees the new entry. The driver pushes each expected result into a queue as it presents the request. The monitor pops and compares only on cycles where the done pulse is high, sampling at the falling edge, so a result that arrives late, early or not at all shows up as a mismatch or as a leftover item. Replacement order is observed only through later lookups: an entry that was displaced must miss, and the replacing entry must hit.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int BASE_SHIFT = 13;

  typedef enum logic [1:0] {
    WR_TAG      = 2'd0,
    WR_PART     = 2'd1,
    WR_DATA_IN  = 2'd2,
    WR_DATA_IDX = 2'd3
  } wr_kind_e;

  // extra offset bits above the 8 KiB base page
  function automatic logic [4:0] ext_shift(input logic [2:0] code);
    return 5'(code) * 5'd3;
  endfunction
endpackage

// File: rtl/tlb_pte_fmt.sv
`timescale 1ns/1ps
module tlb_pte_fmt #(
  parameter int PA_W = 40
) (
  input  logic                 alt_fmt_i,
  input  logic [63:0]          word_i,
  output logic                 valid_o,
  output logic [2:0]           size_o,
  output logic [PA_W-14:0]     ppn_o
);
  logic [2:0] sz;

  always_comb begin
    if (alt_fmt_i) sz = word_i[2:0];
    else           sz = {word_i[48], word_i[62:61]};
  end

  assign size_o  = sz;
  assign valid_o = word_i[63] && (sz < 3'd6);
  assign ppn_o   = word_i[PA_W-1:13];

  logic unused_attr;
  assign unused_attr = ^{word_i[60:49], word_i[47:PA_W], word_i[12:3]};
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] used_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ENTRIES-1:0] cand;
  assign cand = ~valid_i | ~used_i;

  always_comb begin
    idx_o = IDX_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end

  p_victim_cand_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand != '0) |-> cand[idx_o]);
  p_victim_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i && &used_i) |-> (idx_o == IDX_W'(ENTRIES - 1)));
endmodule

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 51,
  parameter int CTX_W   = 13,
  parameter int PART_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ENTRIES-1:0]              valid_i,
  input  logic [ENTRIES-1:0]              real_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_i,
  input  logic [ENTRIES-1:0][CTX_W-1:0]   ctx_i,
  input  logic [ENTRIES-1:0][PART_W-1:0]  part_i,
  input  logic [ENTRIES-1:0][2:0]         size_i,
  input  logic [VPN_W-1:0]                q_vpn_i,
  input  logic [CTX_W-1:0]                q_ctx_i,
  input  logic [PART_W-1:0]               q_part_i,
  input  logic                            q_real_i,
  output logic                            any_o,
  output logic [IDX_W-1:0]                idx_o
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] cmp_mask;
    assign cmp_mask   = ~((VPN_W'(1) << ext_shift(size_i[g])) - VPN_W'(1));
    assign hit_vec[g] = valid_i[g] && (real_i[g] == q_real_i) &&
                        (ctx_i[g] == q_ctx_i) && (part_i[g] == q_part_i) &&
                        (((vpn_i[g] ^ q_vpn_i) & cmp_mask) == '0);
  end

  assign any_o = |hit_vec;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  p_cam_pick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (hit_vec[idx_o] && valid_i[idx_o]));
endmodule

// File: rtl/tlb_assoc.sv
`timescale 1ns/1ps
module tlb_assoc import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 13,
  parameter int PART_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [10:3]       wr_addr_i,
  input  logic [63:0]       wr_data_i,
  input  logic              lk_valid_i,
  input  logic [63:0]       lk_va_i,
  input  logic [CTX_W-1:0]  lk_ctx_i,
  input  logic              lk_real_i,
  input  logic [1:0]        lk_size_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_misalign_o,
  output logic [PA_W-1:0]   lk_pa_o
);
  localparam int VA_W  = 64;
  localparam int VPN_W = VA_W - BASE_SHIFT;
  localparam int PPN_W = PA_W - BASE_SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VA_W-1:0]   tag_q;
  logic [PART_W-1:0] part_q;

  logic [ENTRIES-1:0]             valid_q, used_q, real_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][CTX_W-1:0]  ctx_q;
  logic [ENTRIES-1:0][PART_W-1:0] ent_part_q;
  logic [ENTRIES-1:0][2:0]        size_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

  // write decode
  logic wr_tag, wr_part, ins;
  assign wr_tag  = wr_en_i && (wr_kind_e'(wr_kind_i) == WR_TAG);
  assign wr_part = wr_en_i && (wr_kind_e'(wr_kind_i) == WR_PART);
  assign ins     = wr_en_i && ((wr_kind_e'(wr_kind_i) == WR_DATA_IN) ||
                               (wr_kind_e'(wr_kind_i) == WR_DATA_IDX));

  logic             pte_valid;
  logic [2:0]       pte_size;
  logic [PPN_W-1:0] pte_ppn;

  tlb_pte_fmt #(.PA_W(PA_W)) u_fmt (
    .alt_fmt_i (wr_addr_i[10]),
    .word_i    (wr_data_i),
    .valid_o   (pte_valid),
    .size_o    (pte_size),
    .ppn_o     (pte_ppn)
  );

  logic [IDX_W-1:0] victim_idx, tgt;

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .used_i  (used_q),
    .idx_o   (victim_idx)
  );

  assign tgt = (wr_kind_e'(wr_kind_i) == WR_DATA_IDX) ? wr_addr_i[IDX_W+2:3] : victim_idx;

  // lookup
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic [2:0]       amask;
  logic             misal;

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .real_i   (real_q),
    .vpn_i    (vpn_q),
    .ctx_i    (ctx_q),
    .part_i   (ent_part_q),
    .size_i   (size_q),
    .q_vpn_i  (lk_va_i[VA_W-1:BASE_SHIFT]),
    .q_ctx_i  (lk_ctx_i),
    .q_part_i (part_q),
    .q_real_i (lk_real_i),
    .any_o    (lk_any),
    .idx_o    (lk_idx)
  );

  assign amask = 3'((4'd1 << lk_size_i) - 4'd1);
  assign misal = (lk_va_i[2:0] & amask) != 3'd0;

  logic            lk_take;
  logic [PA_W-1:0] off_mask, pa_next;
  assign lk_take  = lk_valid_i && !misal && lk_any;
  assign off_mask = (PA_W'(1) << (BASE_SHIFT + int'(ext_shift(size_q[lk_idx])))) - PA_W'(1);
  assign pa_next  = ({ppn_q[lk_idx], {BASE_SHIFT{1'b0}}} & ~off_mask) |
                    (lk_va_i[PA_W-1:0] & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      part_q <= '0;
    end else begin
      if (wr_tag)  tag_q  <= wr_data_i;
      if (wr_part) part_q <= wr_data_i[PART_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      if (lk_take) used_q[lk_idx] <= 1'b1;
      if (ins) begin
        valid_q[tgt] <= pte_valid;
        used_q[tgt]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins) begin
      vpn_q[tgt]      <= tag_q[VA_W-1:BASE_SHIFT];
      ctx_q[tgt]      <= tag_q[CTX_W-1:0];
      ent_part_q[tgt] <= part_q;
      real_q[tgt]     <= wr_addr_i[9];
      size_q[tgt]     <= pte_size;
      ppn_q[tgt]      <= pte_ppn;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o     <= 1'b0;
      lk_hit_o      <= 1'b0;
      lk_miss_o     <= 1'b0;
      lk_misalign_o <= 1'b0;
      lk_pa_o       <= '0;
    end else begin
      lk_done_o     <= lk_valid_i;
      lk_hit_o      <= lk_take;
      lk_miss_o     <= lk_valid_i && !misal && !lk_any;
      lk_misalign_o <= lk_valid_i && misal;
      lk_pa_o       <= lk_take ? pa_next : '0;
    end
  end

  // assertion-side tracking of the last insert
  logic             ins_q, newv_q;
  logic [IDX_W-1:0] tgt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q  <= 1'b0;
      newv_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      ins_q  <= ins;
      newv_q <= pte_valid;
      tgt_q  <= tgt;
    end
  end

  p_insert_fresh_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_q |-> ((valid_q[tgt_q] == newv_q) && !used_q[tgt_q]));
  p_one_outcome_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> ($countones({lk_hit_o, lk_miss_o, lk_misalign_o}) == 1));
  p_done_lat_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o);
  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_done_o && !lk_hit_o && !lk_miss_o && !lk_misalign_o);
  p_misalign_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && ((lk_va_i[2:0] & amask) != 3'd0)) |=> (lk_misalign_o && lk_pa_o == '0));
  p_pa_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_pa_o == '0));
endmodule

// File: tb/tlb_assoc_test.sv
`timescale 1ns/1ps
module tlb_assoc_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_kind_i = '0;
  logic [10:3] wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        lk_valid_i = 1'b0;
  logic [63:0] lk_va_i = '0;
  logic [12:0] lk_ctx_i = '0;
  logic        lk_real_i = 1'b0;
  logic [1:0]  lk_size_i = '0;
  logic        lk_done_o, lk_hit_o, lk_miss_o, lk_misalign_o;
  logic [39:0] lk_pa_o;

  always #5 clk = ~clk;

  tlb_assoc uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .lk_valid_i(lk_valid_i), .lk_va_i(lk_va_i), .lk_ctx_i(lk_ctx_i),
    .lk_real_i(lk_real_i), .lk_size_i(lk_size_i),
    .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o),
    .lk_misalign_o(lk_misalign_o), .lk_pa_o(lk_pa_o)
  );

  typedef struct {
    logic [42:0] res; // {hit, miss, misalign, pa}
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] xpa(input logic [39:0] pa, input logic [63:0] va, input int code);
    logic [39:0] m;
    m = (40'd1 << (13 + 3 * code)) - 40'd1;
    return (pa & ~m) | (va[39:0] & m);
  endfunction

  function automatic logic [63:0] mk_word(input bit alt, input bit v, input logic [2:0] code, input logic [39:0] pa);
    logic [63:0] w;
    w = {24'd0, pa[39:13], 13'd0};
    w[63] = v;
    if (alt) w[2:0] = code;
    else begin
      w[62:61] = code[1:0];
      w[48]    = code[2];
    end
    return w;
  endfunction

  task automatic wr(input logic [1:0] kind, input logic [10:3] addr, input logic [63:0] data);
    @(negedge clk);
    lk_valid_i = 1'b0;
    wr_en_i = 1'b1; wr_kind_i = kind; wr_addr_i = addr; wr_data_i = data;
  endtask

  task automatic set_tag(input logic [63:0] va, input logic [12:0] ctx);
    wr(2'd0, '0, {va[63:13], ctx});
  endtask

  task automatic set_part(input logic [7:0] p);
    wr(2'd1, '0, {56'd0, p});
  endtask

  task automatic ins_idx(input int idx, input bit rl, input bit alt, input logic [63:0] w);
    wr(2'd3, {alt, rl, 6'(idx)}, w);
  endtask

  task automatic ins_scan(input bit rl, input bit alt, input logic [63:0] w);
    wr(2'd2, {alt, rl, 6'd0}, w);
  endtask

  task automatic look(input logic [63:0] va, input logic [12:0] ctx, input bit rl, input logic [1:0] sz,
                      input bit h, input bit m, input bit a, input logic [39:0] pa, input string req);
    exp_t e;
    @(negedge clk);
    wr_en_i = 1'b0;
    lk_valid_i = 1'b1; lk_va_i = va; lk_ctx_i = ctx; lk_real_i = rl; lk_size_i = sz;
    e.res = {h, m, a, pa};
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en_i = 1'b0;
    lk_valid_i = 1'b0;
  endtask

  // monitor: results are due one cycle after the request
  always @(negedge clk) begin
    if (rst_ni && lk_done_o) begin
      if (q.size() == 0) chk(1'b0, "R13 unexpected result", {21'd0, lk_hit_o, lk_miss_o, lk_misalign_o, lk_pa_o}, '0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({lk_hit_o, lk_miss_o, lk_misalign_o, lk_pa_o} == e.res, e.req,
            {21'd0, lk_hit_o, lk_miss_o, lk_misalign_o, lk_pa_o}, {21'd0, e.res});
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", '0, '1);
    finish_run();
  end

  localparam logic [63:0] VA_A = 64'h0000_1234_5678_A000;
  localparam logic [63:0] VA_B = 64'h0000_4444_0000_2000;
  localparam logic [39:0] PA_A = 40'hAB_CDEF_2000;
  localparam logic [39:0] PA_B = 40'h12_3456_6000;

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk({lk_done_o, lk_hit_o, lk_miss_o, lk_misalign_o, lk_pa_o} == '0, "R13 reset outputs",
        {20'd0, lk_done_o, lk_hit_o, lk_miss_o, lk_misalign_o, lk_pa_o}, '0);
    rst_ni = 1'b1;
    idle();

    // R12: empty table misses
    look(VA_A, 13'd7, 0, 2'd0, 0, 1, 0, '0, "R12 miss on empty");

    // R1, R4: scan insert on empty table goes to slot 0
    set_part(8'd5);
    set_tag(VA_A, 13'd7);
    ins_scan(0, 0, mk_word(0, 1, 3'd0, PA_A));
    look(VA_A + 64'h123, 13'd7, 0, 2'd0, 1, 0, 0, xpa(PA_A, VA_A + 64'h123, 0), "R1 hit after tag+insert");
    look(VA_A + 64'h123, 13'd8, 0, 2'd0, 0, 1, 0, '0, "R1 context mismatch");
    look(VA_A, 13'd7, 1, 2'd0, 0, 1, 0, '0, "R6 real flag mismatch");
    look(VA_A + 64'h2000, 13'd7, 0, 2'd0, 0, 1, 0, '0, "R9 next 8K page misses");

    // R3/R4: indexed insert at 0 displaces the scan-inserted entry
    set_tag(VA_B, 13'd9);
    ins_idx(0, 0, 0, mk_word(0, 1, 3'd0, PA_B));
    look(VA_A, 13'd7, 0, 2'd0, 0, 1, 0, '0, "R4 scan had chosen slot 0");
    look(VA_B + 64'h18, 13'd9, 0, 2'd3, 1, 0, 0, xpa(PA_B, VA_B + 64'h18, 0), "R3 indexed insert hit");

    // R2: partition compare
    set_part(8'd6);
    look(VA_B, 13'd9, 0, 2'd0, 0, 1, 0, '0, "R2 other partition misses");
    set_part(8'd5);
    look(VA_B, 13'd9, 0, 2'd0, 1, 0, 0, xpa(PA_B, VA_B, 0), "R2 partition restored");

    // R9: 4 MiB page, native encoding, physical page not size-aligned
    set_tag(64'h0000_2000_0040_0000, 13'd20);
    ins_idx(1, 0, 0, mk_word(0, 1, 3'd3, 40'h00_8041_2000));
    look(64'h0000_2000_0055_1238, 13'd20, 0, 2'd3, 1, 0, 0,
         xpa(40'h00_8041_2000, 64'h0000_2000_0055_1238, 3), "R9 4MiB page");
    look(64'h0000_2000_0080_0000, 13'd20, 0, 2'd0, 0, 1, 0, '0, "R9 beyond 4MiB page");

    // R7: alternate encoding, 256 MiB page
    set_tag(64'h0000_3000_0000_0000, 13'd21);
    ins_idx(2, 0, 1, mk_word(1, 1, 3'd5, 40'h30_1000_0000));
    look(64'h0000_3000_0ABC_DEF0, 13'd21, 0, 2'd2, 1, 0, 0,
         xpa(40'h30_1000_0000, 64'h0000_3000_0ABC_DEF0, 5), "R7 alternate encoding 256MiB");

    // R10: invalid size code; R14: valid bit clear
    set_tag(64'h0000_5000_0000_0000, 13'd22);
    ins_idx(3, 0, 1, mk_word(1, 1, 3'd6, 40'h01_0000_0000));
    look(64'h0000_5000_0000_0000, 13'd22, 0, 2'd0, 0, 1, 0, '0, "R10 size code 6 never hits");
    set_tag(64'h0000_5100_0000_0000, 13'd23);
    ins_idx(4, 0, 0, mk_word(0, 1, 3'd7, 40'h01_0000_0000));
    look(64'h0000_5100_0000_0000, 13'd23, 0, 2'd0, 0, 1, 0, '0, "R10 size code 7 never hits");
    set_tag(64'h0000_5200_0000_0000, 13'd24);
    ins_idx(5, 0, 0, mk_word(0, 0, 3'd0, 40'h01_0000_0000));
    look(64'h0000_5200_0000_0000, 13'd24, 0, 2'd0, 0, 1, 0, '0, "R14 valid bit clear");

    // R11: misalignment beats a mapped hit
    look(VA_B + 64'h4, 13'd9, 0, 2'd3, 0, 0, 1, '0, "R11 8-byte access misaligned");
    look(VA_B + 64'h1, 13'd9, 0, 2'd1, 0, 0, 1, '0, "R11 2-byte access misaligned");
    look(VA_B + 64'h3, 13'd9, 0, 2'd0, 1, 0, 0, xpa(PA_B, VA_B + 64'h3, 0), "R11 byte access any address");

    // R6: real-mode entry
    set_tag(64'h0000_6000_0000_4000, 13'd0);
    ins_idx(6, 1, 0, mk_word(0, 1, 3'd0, 40'h00_0600_4000));
    look(64'h0000_6000_0000_4010, 13'd0, 1, 2'd0, 1, 0, 0, 40'h00_0600_4010, "R6 real entry hit");
    look(64'h0000_6000_0000_4010, 13'd0, 0, 2'd0, 0, 1, 0, '0, "R6 real entry vs normal lookup");

    // R12: duplicate mapping, lowest index wins
    set_tag(VA_B, 13'd9);
    ins_idx(7, 0, 0, mk_word(0, 1, 3'd0, 40'h77_7777_E000));
    look(VA_B, 13'd9, 0, 2'd0, 1, 0, 0, xpa(PA_B, VA_B, 0), "R12 lowest index wins");

    // R5/R8: fill all slots, hit all (sets used), scan falls back to last
    for (int i = 0; i < 64; i++) begin
      set_tag(64'h0000_7000_0000_0000 + (64'(i) << 13), 13'(100 + i));
      ins_idx(i, 0, 0, mk_word(0, 1, 3'd0, 40'h10_0000_0000 + (40'(i) << 13)));
    end
    for (int i = 0; i < 64; i++) begin
      look(64'h0000_7000_0000_0000 + (64'(i) << 13) + 64'h8, 13'(100 + i), 0, 2'd3, 1, 0, 0,
           40'h10_0000_0008 + (40'(i) << 13), "R8 fill hit");
    end
    set_tag(64'h0000_7100_0000_0000, 13'd300);
    ins_scan(0, 0, mk_word(0, 1, 3'd0, 40'h20_0000_0000));
    look(64'h0000_7000_0000_0000 + (64'd63 << 13), 13'd163, 0, 2'd0, 0, 1, 0, '0, "R5 last slot replaced");
    look(64'h0000_7100_0000_0000, 13'd300, 0, 2'd0, 1, 0, 0, 40'h20_0000_0000, "R5 new entry in last slot");
    look(64'h0000_7000_0000_0000 + (64'd62 << 13), 13'd162, 0, 2'd0, 1, 0, 0,
         40'h10_0000_0000 + (40'd62 << 13), "R5 slot 62 kept");

    // R3/R4/R8: a reinserted slot has used clear and becomes the scan victim
    set_tag(64'h0000_7200_0000_0000, 13'd301);
    ins_idx(5, 0, 0, mk_word(0, 1, 3'd0, 40'h21_0000_0000));
    set_tag(64'h0000_7300_0000_0000, 13'd302);
    ins_scan(0, 0, mk_word(0, 1, 3'd0, 40'h22_0000_0000));
    look(64'h0000_7200_0000_0000, 13'd301, 0, 2'd0, 0, 1, 0, '0, "R4 unused slot 5 chosen");
    look(64'h0000_7300_0000_0000, 13'd302, 0, 2'd0, 1, 0, 0, 40'h22_0000_0000, "R4 scan insert hit");
    look(64'h0000_7000_0000_0000 + (64'd4 << 13), 13'd104, 0, 2'd0, 1, 0, 0,
         40'h10_0000_0000 + (40'd4 << 13), "R3 neighbour slot intact");

    idle();
    idle();
    idle();
    chk(q.size() == 0, "R13 all results delivered", 64'(q.size()), '0);
    finish_run();
  end
endmodule